// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

After reset this block brings a DDR2 memory from power-on to a usable state. It holds the clock enable low and drives no-operation for the power-up settling interval. It then raises the clock enable and issues the fixed bring-up command list: precharge-all, the second and third extended mode registers, DLL enable, a mode write with DLL reset, DLL lock wait, precharge-all, two auto-refreshes, the operating mode write, and the off-chip-driver default and exit writes. Each command sits on the active-low RAS/CAS/WE lines for exactly one controller cycle, with the bank address and address bus valid in the same cycle. No-operation is driven on every other cycle.

Every wait between steps is a cycle count. The block computes it at elaboration from the clock period and nanosecond timing parameters, and no gap is ever shorter than the mode-register set delay. When the list is complete, the block raises an init-done flag and a calibration-start request. It holds the request until the datapath reports calibration done, and only then asserts ready. The burst length, burst type, CAS latency, write recovery and additive latency written into the mode registers are parameters.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While reset is asserted, cke_o is 0, {ras_n_o,cas_n_o,we_n_o} is 3'b111 (NOP), and init_done_o, cal_start_o and ready_o are 0.
- R2: After reset is released, cke_o stays 0 with NOP on the command lines for GAP_PWRUP cycles (T_PWRUP_NS converted to cycles), then rises and stays high.
- R3: The first command is precharge-all (RAS/CAS/WE = L,H,L) with addr_o[10]=1, issued GAP_CKE cycles after cke_o rises (T_CKE_NS converted).
- R4: The next two commands are load-mode (L,L,L) with ba_o=2'b10 and then ba_o=2'b11, both with addr_o all zero.
- R5: Next comes a load-mode with ba_o=2'b01 and addr_o[0]=0 (DLL enabled), additive latency on addr_o[5:3] and addr_o[9:7]=0.
- R6: Next comes a load-mode with ba_o=2'b00 and addr_o[8]=1 (DLL reset). The following command comes DLL_LOCK_CYC cycles later.
- R7: Next come precharge-all, then two auto-refreshes (L,L,H) spaced by GAP_RFC cycles, then a load-mode with ba_o=2'b00 and addr_o[8]=0.
- R8: The last two commands are load-mode with ba_o=2'b01: the first has addr_o[9:7]=3'b111 and the second has addr_o[9:7]=3'b000. The other bits match R5.
- R9: Each command lasts one cycle, and no two commands are closer than T_MRD_CYC (at least 2). Exactly eleven commands are issued per bring-up.
- R10: One gap after the last command, init_done_o and cal_start_o rise. cal_start_o stays high until a cycle with cal_done_i=1. ready_o then rises on the following edge, cal_start_o falls, and ready_o stays high. cal_done_i has no effect before init_done_o.
- R11: Both mode writes carry burst length on addr_o[2:0] (3'b010 for 4, 3'b011 for 8), burst type on addr_o[3], CAS latency in binary on addr_o[6:4], and write recovery minus one on addr_o[11:9].
- R12: Reset asserted mid-sequence returns the block to the start of the power-up wait. After release, the full sequence is issued again from the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_done_i | input | 1 | Read calibration finished |
| cke_o | output | 1 | Memory clock enable |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address / mode register select |
| addr_o | output | ADDR_W | Address bus / mode register value |
| init_done_o | output | 1 | Bring-up command list complete |
| cal_start_o | output | 1 | Calibration request, held until done |
| ready_o | output | 1 | Sequencer idle and memory usable |

## Verification
The bench targets the exact cycle of the CKE rise and the spacing before every command. An off-by-one wait counter would move the CKE edge or shift one gap by a cycle. A wrong step order or bank select would put an extended-mode write into the wrong register. The bench also drives mode parameters that differ from the defaults, so a swapped or misaligned field would show up in the burst-length, latency or write-recovery bits of both mode writes. Finally, it pulses calibration-done early, holds it off after init, and resets the block in the middle of the DLL wait. A design that leaked the early pulse would report ready too soon, and a design that restarted from the wrong step would skip the power-up wait.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_CKE,
    ST_PREA0,
    ST_EMR2,
    ST_EMR3,
    ST_EMR1_DLL,
    ST_MR_DLLRST,
    ST_PREA1,
    ST_REF0,
    ST_REF1,
    ST_MR_RUN,
    ST_EMR1_OCD,
    ST_EMR1_EXIT,
    ST_DONE,
    ST_READY
  } step_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ps);
    return max_u(1, (ns * 1000 + clk_ps - 1) / clk_ps);
  endfunction

  function automatic logic [15:0] mr_word(int unsigned bl, int unsigned bt,
                                          int unsigned cl, int unsigned wr,
                                          logic dll_rst);
    logic [15:0] w;
    int unsigned wm1;
    w       = '0;
    w[2:0]  = (bl == 8) ? 3'b011 : 3'b010;
    w[3]    = bt[0];
    w[6:4]  = cl[2:0];
    w[8]    = dll_rst;
    wm1     = wr - 1;
    w[11:9] = wm1[2:0];
    return w;
  endfunction

  function automatic logic [15:0] emr1_word(int unsigned al, logic [2:0] ocd);
    logic [15:0] w;
    w      = '0;
    w[0]   = 1'b0;  // DLL enabled
    w[5:3] = al[2:0];
    w[9:7] = ocd;
    return w;
  endfunction

endpackage

// File: rtl/ddr2_init_gap_timer.sv
module ddr2_init_gap_timer #(
  parameter int unsigned      CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= RST_VAL;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_step_table.sv
module ddr2_init_step_table
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned BA_W       = 2,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned BURST_LEN  = 4,
  parameter int unsigned BURST_TYPE = 0,
  parameter int unsigned CAS_LAT    = 4,
  parameter int unsigned WR_REC     = 4,
  parameter int unsigned ADD_LAT    = 0,
  parameter int unsigned GAP_PWRUP  = 2,
  parameter int unsigned GAP_CKE    = 2,
  parameter int unsigned GAP_RP     = 2,
  parameter int unsigned GAP_RFC    = 2,
  parameter int unsigned GAP_MRD    = 2,
  parameter int unsigned GAP_DLL    = 2
) (
  input  step_e             step_i,
  output cmd_e              cmd_o,
  output logic              cke_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  gap_m1_o
);

  localparam logic [15:0] MR_DLLRST = mr_word(BURST_LEN, BURST_TYPE, CAS_LAT, WR_REC, 1'b1);
  localparam logic [15:0] MR_RUN    = mr_word(BURST_LEN, BURST_TYPE, CAS_LAT, WR_REC, 1'b0);
  localparam logic [15:0] EMR1_BASE = emr1_word(ADD_LAT, 3'b000);
  localparam logic [15:0] EMR1_OCD  = emr1_word(ADD_LAT, 3'b111);

  int unsigned gap;

  always_comb begin
    cmd_o  = CMD_NOP;
    cke_o  = 1'b1;
    ba_o   = '0;
    addr_o = '0;
    gap    = GAP_MRD;
    unique case (step_i)
      ST_PWRUP: begin
        cke_o = 1'b0;
        gap   = GAP_PWRUP;
      end
      ST_CKE: gap = GAP_CKE;
      ST_PREA0, ST_PREA1: begin
        cmd_o      = CMD_PRE;
        addr_o[10] = 1'b1;
        gap        = GAP_RP;
      end
      ST_EMR2: begin
        cmd_o = CMD_LMR;
        ba_o  = BA_W'(2);
      end
      ST_EMR3: begin
        cmd_o = CMD_LMR;
        ba_o  = BA_W'(3);
      end
      ST_EMR1_DLL, ST_EMR1_EXIT: begin
        cmd_o  = CMD_LMR;
        ba_o   = BA_W'(1);
        addr_o = EMR1_BASE[ADDR_W-1:0];
      end
      ST_EMR1_OCD: begin
        cmd_o  = CMD_LMR;
        ba_o   = BA_W'(1);
        addr_o = EMR1_OCD[ADDR_W-1:0];
      end
      ST_MR_DLLRST: begin
        cmd_o  = CMD_LMR;
        addr_o = MR_DLLRST[ADDR_W-1:0];
        gap    = GAP_DLL;
      end
      ST_MR_RUN: begin
        cmd_o  = CMD_LMR;
        addr_o = MR_RUN[ADDR_W-1:0];
      end
      ST_REF0, ST_REF1: begin
        cmd_o = CMD_REF;
        gap   = GAP_RFC;
      end
      default: ;
    endcase
    gap_m1_o = CNT_W'(gap - 1);
  end

endmodule

// File: rtl/ddr2_init_cmd_drv.sv
module ddr2_init_cmd_drv
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  cmd_e              cmd_i,
  input  logic              cke_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o,
  output logic              cke_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= CMD_NOP;
      cke_o  <= 1'b0;
      ba_o   <= '0;
      addr_o <= '0;
    end else if (load_i) begin
      cmd_o  <= cmd_i;
      cke_o  <= cke_i;
      ba_o   <= ba_i;
      addr_o <= addr_i;
    end else begin
      // one-cycle command, NOP otherwise
      cmd_o  <= CMD_NOP;
      ba_o   <= '0;
      addr_o <= '0;
    end
  end

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned CLK_PERIOD_PS = 2500,
  parameter int unsigned T_PWRUP_NS    = 200000,
  parameter int unsigned T_CKE_NS      = 400,
  parameter int unsigned T_RP_NS       = 15,
  parameter int unsigned T_RFC_NS      = 128,
  parameter int unsigned T_MRD_CYC     = 2,
  parameter int unsigned DLL_LOCK_CYC  = 200,
  parameter int unsigned BURST_LEN     = 4,
  parameter int unsigned BURST_TYPE    = 0,
  parameter int unsigned CAS_LAT       = 4,
  parameter int unsigned WR_REC        = 4,
  parameter int unsigned ADD_LAT       = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_done_i,
  output logic              cke_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o,
  output logic              cal_start_o,
  output logic              ready_o
);

  localparam int unsigned GAP_MRD   = T_MRD_CYC;
  localparam int unsigned GAP_PWRUP = max_u(GAP_MRD, ns_to_cyc(T_PWRUP_NS, CLK_PERIOD_PS));
  localparam int unsigned GAP_CKE   = max_u(GAP_MRD, ns_to_cyc(T_CKE_NS, CLK_PERIOD_PS));
  localparam int unsigned GAP_RP    = max_u(GAP_MRD, ns_to_cyc(T_RP_NS, CLK_PERIOD_PS));
  localparam int unsigned GAP_RFC   = max_u(GAP_MRD, ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS));
  localparam int unsigned GAP_DLL   = max_u(GAP_MRD, DLL_LOCK_CYC);
  localparam int unsigned GAP_MAX   = max_u(max_u(GAP_PWRUP, GAP_CKE),
                                            max_u(max_u(GAP_RP, GAP_RFC), GAP_DLL));
  localparam int unsigned CNT_W     = $clog2(GAP_MAX + 1);
  localparam logic [CNT_W-1:0] PWRUP_M1 = CNT_W'(GAP_PWRUP - 1);

  step_e             step_q, step_d, nxt_step;
  logic              expired, advance;
  cmd_e              tbl_cmd, cmd_q;
  logic              tbl_cke;
  logic [BA_W-1:0]   tbl_ba;
  logic [ADDR_W-1:0] tbl_addr;
  logic [CNT_W-1:0]  tbl_gap_m1;

  assign nxt_step = step_e'(step_q + 4'd1);
  assign advance  = expired && (step_q < ST_DONE);

  always_comb begin
    step_d = step_q;
    if (advance)                                step_d = nxt_step;
    else if (step_q == ST_DONE && cal_done_i)   step_d = ST_READY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_PWRUP;
    else         step_q <= step_d;
  end

  ddr2_init_step_table #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .BURST_LEN(BURST_LEN), .BURST_TYPE(BURST_TYPE), .CAS_LAT(CAS_LAT),
    .WR_REC(WR_REC), .ADD_LAT(ADD_LAT),
    .GAP_PWRUP(GAP_PWRUP), .GAP_CKE(GAP_CKE), .GAP_RP(GAP_RP),
    .GAP_RFC(GAP_RFC), .GAP_MRD(GAP_MRD), .GAP_DLL(GAP_DLL)
  ) i_table (
    .step_i   (nxt_step),
    .cmd_o    (tbl_cmd),
    .cke_o    (tbl_cke),
    .ba_o     (tbl_ba),
    .addr_o   (tbl_addr),
    .gap_m1_o (tbl_gap_m1)
  );

  ddr2_init_gap_timer #(
    .CNT_W(CNT_W), .RST_VAL(PWRUP_M1)
  ) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (advance),
    .load_val_i (tbl_gap_m1),
    .expired_o  (expired)
  );

  ddr2_init_cmd_drv #(
    .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) i_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (advance),
    .cmd_i  (tbl_cmd),
    .cke_i  (tbl_cke),
    .ba_i   (tbl_ba),
    .addr_i (tbl_addr),
    .cmd_o  (cmd_q),
    .cke_o  (cke_o),
    .ba_o   (ba_o),
    .addr_o (addr_o)
  );

  assign {ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign init_done_o = (step_q == ST_DONE) || (step_q == ST_READY);
  assign cal_start_o = (step_q == ST_DONE);
  assign ready_o     = (step_q == ST_READY);

endmodule

// File: rtl/ddr2_pwrup_seq_chk.sv
module ddr2_pwrup_seq_chk #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned T_MRD_CYC  = 2,
  parameter int unsigned BURST_LEN  = 4,
  parameter int unsigned CAS_LAT    = 4,
  parameter int unsigned WR_REC     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cal_done_i,
  input logic              cke_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              init_done_o,
  input logic              cal_start_o,
  input logic              ready_o
);

  logic [2:0] cmd;
  assign cmd = {ras_n_o, cas_n_o, we_n_o};

  initial begin
    a_r9_mrd_min: assert (T_MRD_CYC >= 2);
    a_r11_bl_legal: assert (BURST_LEN == 4 || BURST_LEN == 8);
    a_r11_cl_legal: assert (CAS_LAT >= 2 && CAS_LAT <= 5);
    a_r11_wr_legal: assert (WR_REC >= 2 && WR_REC <= 6);
    a_r5_addr_wide: assert (ADDR_W >= 12 && ADDR_W <= 16);
  end

  a_r2_nop_while_cke_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cmd == 3'b111);

  a_r2_cke_stays_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  a_r9_one_cycle_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd != 3'b111 |=> cmd == 3'b111);

  a_r3_prea_all_a10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == 3'b010 |-> addr_o[10]);

  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r10_no_cmd_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> cmd == 3'b111);

  a_r10_cal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o && !cal_done_i |=> cal_start_o);

  a_r10_ready_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(cal_done_i) && $past(cal_start_o));

  a_r10_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cal_start_o, ready_o}));

endmodule

bind ddr2_pwrup_seq ddr2_pwrup_seq_chk #(
  .ADDR_W(ADDR_W), .T_MRD_CYC(T_MRD_CYC), .BURST_LEN(BURST_LEN),
  .CAS_LAT(CAS_LAT), .WR_REC(WR_REC)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cal_done_i  (cal_done_i),
  .cke_o       (cke_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .addr_o      (addr_o),
  .init_done_o (init_done_o),
  .cal_start_o (cal_start_o),
  .ready_o     (ready_o)
);

// File: tb/test_ddr2_pwrup_seq.sv
module test_ddr2_pwrup_seq;

  localparam int CLK_PS = 20000;
  localparam int BL = 8, BT = 1, CL = 5, WR = 6, AL = 2;
  localparam int G_PWRUP = 10000;  // 200 us / 20 ns
  localparam int G_CKE   = 20;     // 400 ns
  localparam int G_RP    = 2;      // max(tMRD, 1)
  localparam int G_RFC   = 7;      // ceil(128 / 20)
  localparam int G_MRD   = 2;
  localparam int G_DLL   = 200;
  localparam logic [2:0] C_LMR = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_NOP = 3'b111;

  typedef struct {
    logic [2:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    int          gap;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_done = 1'b0;
  logic        cke, ras_n, cas_n, we_n, init_done, cal_start, ready;
  logic [1:0]  ba;
  logic [12:0] addr;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   mon_en = 1'b0;
  bit   finished = 1'b0;
  int   since = 0;
  logic cke_prev = 1'b0;

  always #10ns clk = ~clk;

  ddr2_pwrup_seq #(
    .ADDR_W(13), .BA_W(2), .CLK_PERIOD_PS(CLK_PS),
    .BURST_LEN(BL), .BURST_TYPE(BT), .CAS_LAT(CL), .WR_REC(WR), .ADD_LAT(AL)
  ) i_ddr2_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_n), .cal_done_i(cal_done),
    .cke_o(cke), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr),
    .init_done_o(init_done), .cal_start_o(cal_start), .ready_o(ready)
  );

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic logic [12:0] mr_exp(bit dll);
    return 13'((WR - 1) << 9) | 13'(dll << 8) | 13'(CL << 4) | 13'(BT << 3)
         | ((BL == 8) ? 13'd3 : 13'd2);
  endfunction

  function automatic logic [12:0] emr1_exp(bit ocd);
    return 13'(AL << 3) | (ocd ? 13'(7 << 7) : 13'd0);
  endfunction

  task automatic push(logic [2:0] c, logic [1:0] b, logic [12:0] a, int g, string r);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.gap = g; e.req = r;
    q.push_back(e);
  endtask

  task automatic load_expected();
    q.delete();
    push(C_PRE, 2'b00, 13'h400,      G_CKE, "R3");
    push(C_LMR, 2'b10, 13'h0,        G_RP,  "R4");
    push(C_LMR, 2'b11, 13'h0,        G_MRD, "R4");
    push(C_LMR, 2'b01, emr1_exp(0),  G_MRD, "R5");
    push(C_LMR, 2'b00, mr_exp(1),    G_MRD, "R6_R11");
    push(C_PRE, 2'b00, 13'h400,      G_DLL, "R6");
    push(C_REF, 2'b00, 13'h0,        G_RP,  "R7");
    push(C_REF, 2'b00, 13'h0,        G_RFC, "R7");
    push(C_LMR, 2'b00, mr_exp(0),    G_RFC, "R7_R11");
    push(C_LMR, 2'b01, emr1_exp(1),  G_MRD, "R8");
    push(C_LMR, 2'b01, emr1_exp(0),  G_MRD, "R8");
  endtask

  // monitor: pops expected commands as they appear
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      logic [2:0] c;
      c = {ras_n, cas_n, we_n};
      since++;
      if (cke && !cke_prev) since = 0;
      cke_prev = cke;
      if (c != C_NOP) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "extra command", int'(c), int'(C_NOP));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(c == e.cmd,     e.req, "command", int'(c), int'(e.cmd));
          chk(ba == e.ba,     e.req, "bank", int'(ba), int'(e.ba));
          chk(addr == e.addr, e.req, "address", int'(addr), int'(e.addr));
          chk(since == e.gap, e.req, "gap", since, e.gap);
        end
        since = 0;
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2ns;
    end
  endtask

  task automatic check_reset_state(string r);
    chk(cke == 1'b0, r, "cke in reset", int'(cke), 0);
    chk({ras_n, cas_n, we_n} == C_NOP, r, "cmd in reset", int'({ras_n, cas_n, we_n}), int'(C_NOP));
    chk({init_done, cal_start, ready} == 3'b000, r, "flags in reset",
        int'({init_done, cal_start, ready}), 0);
  endtask

  task automatic start_run();
    load_expected();
    cke_prev = 1'b0;
    since = 0;
    mon_en = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic check_cke_edge();
    tick(50);
    cal_done = 1'b1;  // R10: early done is ignored
    tick(1);
    cal_done = 1'b0;
    chk(ready == 1'b0 && cal_start == 1'b0, "R10", "early cal_done leaked",
        int'({cal_start, ready}), 0);
    tick(G_PWRUP - 1 - 51);
    chk(cke == 1'b0, "R2", "cke before power-up wait ends", int'(cke), 0);
    tick(1);
    chk(cke == 1'b1, "R2", "cke after power-up wait", int'(cke), 1);
  endtask

  initial begin
    tick(3);
    check_reset_state("R1");
    start_run();
    check_cke_edge();

    // R12: reset during the DLL lock wait, then restart
    tick(G_CKE + G_RP + 3 * G_MRD + 50);
    chk(q.size() == 6, "R12", "commands before mid reset", 11 - q.size(), 5);
    rst_n = 1'b0;
    mon_en = 1'b0;
    #1ns;
    check_reset_state("R12");
    tick(2);
    start_run();
    check_cke_edge();

    begin
      int guard = 0;
      while (!init_done && guard < 2000) begin
        tick(1);
        guard++;
      end
    end
    chk(init_done == 1'b1, "R10", "init_done", int'(init_done), 1);
    chk(q.size() == 0, "R9", "commands left unissued", q.size(), 0);
    chk(cal_start == 1'b1 && ready == 1'b0, "R10", "cal request at init",
        int'({cal_start, ready}), 2);
    tick(20);
    chk(cal_start == 1'b1 && ready == 1'b0, "R10", "cal request held",
        int'({cal_start, ready}), 2);
    cal_done = 1'b1;
    tick(1);
    cal_done = 1'b0;
    chk(ready == 1'b1 && cal_start == 1'b0, "R10", "ready after cal_done",
        int'({cal_start, ready}), 1);
    tick(10);
    chk(ready == 1'b1 && init_done == 1'b1, "R10", "ready held",
        int'({init_done, ready}), 3);
    chk({ras_n, cas_n, we_n} == C_NOP, "R9", "idle command", int'({ras_n, cas_n, we_n}), int'(C_NOP));
    chk(q.size() == 0, "R9", "no extra commands", q.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20ns);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule